// File: doc/BRIEF.md
# Line Burst Bus Master

This block moves one 16-byte cache line between an internal requester and an external bus. A request carries a direction, a start address and, for stores, the whole line. The block opens the transaction as a burst and then shapes the rest from how the slave answers the first beat. A burstable 32-bit slave gets four word beats. A slave that reports a 16-bit or 8-bit port before its first acknowledge, and does not inhibit, gets a burst of 8 or 16 narrow beats. A slave that raises burst inhibit with the first acknowledge gets the rest of the line as separate single cycles, each with its own transfer start and address.

The requester side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, a request is taken on any rising edge where both `req_valid` and `req_ready` are high, and the request fields need only be valid on that edge. Completion is a one-cycle `done` pulse with no back-pressure. On a read, `rd_line` holds the fetched line from that pulse until the next request is accepted. Bus arbitration lives elsewhere, and `bus_lock` tells the arbiter not to step in.

Top module: `line_burst_master`

## Requirements
- R1: After reset `req_ready` is high and `bus_ts`, `bus_lock`, `bus_bdip` and `done` are low. A request accepted on an edge makes `bus_ts` high in the next cycle.
- R2: The first transfer start of a request is a single-cycle `bus_ts` with `bus_burst` high, `bus_write` set to the request direction and `bus_addr` equal to the request address with its two low bits cleared.
- R3: While a burst is in progress, `bus_addr` and `bus_write` do not change from the cycle of `bus_ts` until the last acknowledge of that burst.
- R4: `bus_bdip` is high in every cycle of a burst beat that another beat will follow, and low during the last beat. It is never high outside a burst.
- R5: A 32-bit slave that does not inhibit receives exactly 4 beats after one transfer start. With w wait cycles per beat, the transaction keeps the block busy for 1+4(w+1) cycles.
- R6: The slave reports its port size on `bus_ps` by raising `bus_psv` in the cycle before the first acknowledge: code 01 means 16-bit and code 10 means 8-bit. Codes 00 and 11, or no report at all, mean 32-bit. A narrow slave that does not inhibit receives a burst of 8 or 16 beats after one transfer start, and the block stays busy for 1+N(w+1) cycles.
- R7: If `bus_bi` is high together with the first `bus_ta`, the burst ends after that beat. The rest of the line then moves as 3, 7 or 15 single cycles (32/16/8-bit port), each with its own `bus_ts` and with `bus_burst` low, for N(w+2) busy cycles in all. `bus_bi` on any later acknowledge has no effect.
- R8: In single cycles after an inhibit, `bus_addr` is the line base plus (start word offset + k·unit) mod 16, where k = 1..N-1 and the unit is 4, 2 or 1 bytes.
- R9: Line byte i sits at `rd_line`/`req_wdata` bits [127-8i -: 8]. Each beat carries the unit of bytes starting at its line offset, placed most significant first: all 32 data lines for a 32-bit port, lines [31:16] for 16-bit, lines [31:24] for 8-bit.
- R10: `bus_lock` is high in every cycle from the cycle after acceptance through the cycle of the last acknowledge, including all beats of a narrow burst, and low otherwise.
- R11: `done` is a one-cycle pulse in the cycle after the last acknowledge. On a read, `rd_line` then holds the complete line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = store line, 0 = fetch line |
| req_addr | input | ADDR_W | Start address within the line |
| req_wdata | input | 128 | Line to store, byte 0 in the top bits |
| done | output | 1 | One-cycle completion pulse |
| rd_line | output | 128 | Fetched line, byte 0 in the top bits |
| bus_ts | output | 1 | Transfer start |
| bus_addr | output | ADDR_W | Bus address |
| bus_burst | output | 1 | Current transfer is a burst |
| bus_write | output | 1 | Transfer direction, 1 = write |
| bus_bdip | output | 1 | Another burst beat follows this one |
| bus_lock | output | 1 | Bus held for this line transaction |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ta | input | 1 | Transfer acknowledge |
| bus_bi | input | 1 | Burst inhibit |
| bus_psv | input | 1 | Port size report valid |
| bus_ps | input | 2 | Port size code |

## Verification
The embedded properties check, on every cycle, the shape of the bus protocol: the burst start, the fixed address and direction across a burst, no `bus_bdip` outside bursts, the switch to a single cycle right after an inhibited first beat, and the single-cycle `done` that coincides with the release of `bus_lock`. Beat counts, the wrap order of addresses, the lane placement and byte order of the data, and the busy-cycle totals for each port size, inhibit setting and wait setting depend on a whole transaction. Only the bench's scenarios against a behavioural slave that follows `bus_bdip` can show them, by comparing the moved line and the counted cycles.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int LINE_BYTES = 16;
  localparam int BUS_BYTES  = 4;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_W     = 8 * LINE_BYTES;
  localparam int BUS_W      = 8 * BUS_BYTES;

  typedef enum logic [1:0] {PW32 = 2'd0, PW16 = 2'd1, PW8 = 2'd2} port_w_e;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_st_e;

  function automatic port_w_e ps_decode(input logic [1:0] code);
    case (code)
      2'b01:   return PW16;
      2'b10:   return PW8;
      default: return PW32;
    endcase
  endfunction

  // log2 of bytes carried per beat
  function automatic logic [1:0] unit_shift(input port_w_e pw);
    case (pw)
      PW16:    return 2'd1;
      PW8:     return 2'd0;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/lbm_beat_plan.sv
module lbm_beat_plan
  import lbm_pkg::*;
(
  input  port_w_e          pw,
  input  logic [OFF_W-1:0] start_off,
  input  logic [OFF_W-1:0] beat,
  output logic [OFF_W-1:0] off,
  output logic [OFF_W-1:0] last_beat
);
  logic [1:0]       sh;
  logic [OFF_W-1:0] step;

  assign sh        = unit_shift(pw);
  assign step      = beat << sh;
  assign off       = start_off + step;   // wraps inside the line
  assign last_beat = OFF_W'((LINE_BYTES >> sh) - 1);
endmodule

// File: rtl/lbm_line_buf.sv
module lbm_line_buf
  import lbm_pkg::*;
(
  input  logic              clk,
  input  logic              load,
  input  logic [LINE_W-1:0] load_data,
  input  logic              cap,
  input  port_w_e           pw,
  input  logic [OFF_W-1:0]  off,
  input  logic [BUS_W-1:0]  din,
  output logic [BUS_W-1:0]  dout,
  output logic [LINE_W-1:0] line
);
  logic [LINE_W-1:0]    line_q;
  logic [OFF_W-1:0]     lane_idx [BUS_BYTES];
  logic [BUS_BYTES-1:0] lane_en;

  always_comb begin
    for (int j = 0; j < BUS_BYTES; j++) begin
      lane_idx[j] = off + OFF_W'(j);
      lane_en[j]  = j < (1 << int'(unit_shift(pw)));
    end
  end

  // big-endian: line byte i lives in the top-down slot i
  always_comb begin
    for (int j = 0; j < BUS_BYTES; j++)
      dout[BUS_W-1-8*j -: 8] = line_q[8*(LINE_BYTES-1-int'(lane_idx[j])) +: 8];
  end

  always_ff @(posedge clk) begin
    if (load) line_q <= load_data;
    else if (cap) begin
      for (int j = 0; j < BUS_BYTES; j++)
        if (lane_en[j])
          line_q[8*(LINE_BYTES-1-int'(lane_idx[j])) +: 8] <= din[BUS_W-1-8*j -: 8];
    end
  end

  assign line = line_q;
endmodule

// File: rtl/line_burst_master.sv
module line_burst_master
  import lbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [127:0]      req_wdata,
  output logic              done,
  output logic [127:0]      rd_line,
  output logic              bus_ts,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_burst,
  output logic              bus_write,
  output logic              bus_bdip,
  output logic              bus_lock,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic              bus_ta,
  input  logic              bus_bi,
  input  logic              bus_psv,
  input  logic [1:0]        bus_ps
);
  localparam int BASE_W = ADDR_W - OFF_W;

  seq_st_e           st_q;
  logic              single_q, write_q, done_q;
  logic [OFF_W-1:0]  beat_q, start_off_q;
  logic [BASE_W-1:0] base_q;
  port_w_e           pw_q;

  logic              accept, beat_ack, first_inh, cap;
  logic [OFF_W-1:0]  off, last_beat;

  assign accept    = req_valid && req_ready;
  assign beat_ack  = (st_q == ST_WAIT) && bus_ta;
  assign first_inh = beat_ack && !single_q && (beat_q == '0) && bus_bi;
  assign cap       = beat_ack && !write_q;

  lbm_beat_plan u_plan (
    .pw(pw_q), .start_off(start_off_q), .beat(beat_q),
    .off(off), .last_beat(last_beat)
  );

  lbm_line_buf u_buf (
    .clk(clk), .load(accept), .load_data(req_wdata), .cap(cap),
    .pw(pw_q), .off(off), .din(bus_din), .dout(bus_dout), .line(rd_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      single_q    <= 1'b0;
      write_q     <= 1'b0;
      done_q      <= 1'b0;
      beat_q      <= '0;
      start_off_q <= '0;
      base_q      <= '0;
      pw_q        <= PW32;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q        <= ST_START;
        single_q    <= 1'b0;
        write_q     <= req_write;
        beat_q      <= '0;
        base_q      <= req_addr[ADDR_W-1:OFF_W];
        start_off_q <= req_addr[OFF_W-1:0] & ~OFF_W'(3);
        pw_q        <= PW32;
      end else begin
        // port size is learned only ahead of the first acknowledge
        if (st_q != ST_IDLE && !single_q && beat_q == '0 && bus_psv && !beat_ack)
          pw_q <= ps_decode(bus_ps);
        if (st_q == ST_START) st_q <= ST_WAIT;
        else if (beat_ack) begin
          if (first_inh) begin
            single_q <= 1'b1;
            beat_q   <= OFF_W'(1);
            st_q     <= ST_START;
          end else if (beat_q == last_beat) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            beat_q <= beat_q + 1'b1;
            if (single_q) st_q <= ST_START;
          end
        end
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign bus_ts    = (st_q == ST_START);
  assign bus_lock  = (st_q != ST_IDLE);
  assign bus_burst = bus_lock && !single_q;
  assign bus_bdip  = bus_burst && (beat_q != last_beat);
  assign bus_write = write_q;
  assign bus_addr  = {base_q, (single_q ? off : start_off_q)};
  assign done      = done_q;

  // R1
  accept_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_ts);
  // R2
  open_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> bus_ts && bus_burst);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_burst && !bus_ts |-> $stable(bus_addr) && $stable(bus_write));
  // R4
  bdip_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_burst |-> !bus_bdip);
  // R7
  inhibit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_inh |=> bus_ts && !bus_burst);
  // R10
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_lock && $past(bus_lock));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/line_burst_master_test.sv
module line_burst_master_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic         req_ready, done;
  logic [127:0] rd_line;
  logic         bus_ts, bus_burst, bus_write, bus_bdip, bus_lock;
  logic [31:0]  bus_addr, bus_dout;
  logic [31:0]  bus_din = '0;
  logic         bus_ta = 1'b0, bus_bi = 1'b0, bus_psv = 1'b0;
  logic [1:0]   bus_ps = 2'b00;

  always #10 clk = ~clk;  // 50 MHz

  line_burst_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_line(rd_line), .bus_ts(bus_ts), .bus_addr(bus_addr),
    .bus_burst(bus_burst), .bus_write(bus_write), .bus_bdip(bus_bdip),
    .bus_lock(bus_lock), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_ta(bus_ta), .bus_bi(bus_bi), .bus_psv(bus_psv), .bus_ps(bus_ps)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model: port code 0=32-bit 1=16-bit 2=8-bit
  int       sl_pw = 0, sl_wait = 0;
  bit       sl_bi = 0;
  logic [7:0] mem [16];

  initial begin
    bit active = 0, first = 0, burst = 0, wr = 0, cont;
    int rem = 0, ub;
    logic [3:0] off = '0;
    forever begin
      @(negedge clk);
      ub = 4 >> sl_pw;
      if (!active) begin
        bus_ta = 0; bus_bi = 0; bus_psv = 0; bus_din = '0;
        if (rst_n && bus_ts) begin
          active = 1; first = 1; burst = bus_burst; wr = bus_write;
          off = bus_addr[3:0]; rem = sl_wait;
          bus_psv = (rem == 0) && (sl_pw != 0);
          bus_ps  = 2'(sl_pw);
        end
      end else if (rem > 0) begin
        rem--;
        bus_ta = 0;
        bus_psv = (rem == 0) && first && (sl_pw != 0);
      end else begin
        bus_ta = 1; bus_psv = 0; bus_bi = first && sl_bi;
        bus_din = '0;
        for (int j = 0; j < ub; j++) begin
          if (wr) mem[4'(off + 4'(j))] = bus_dout[31-8*j -: 8];
          else    bus_din[31-8*j -: 8] = mem[4'(off + 4'(j))];
        end
        cont = burst && bus_bdip && !(first && sl_bi);
        first = 0; off = off + 4'(ub); rem = sl_wait;
        if (!cont) active = 0;
      end
    end
  end

  typedef struct {
    bit wr; logic [127:0] line; int ts_n; int lock_n; logic [31:0] addr0; int id;
  } exp_t;
  exp_t sb[$];

  function automatic logic [127:0] mem_line();
    logic [127:0] l;
    for (int i = 0; i < 16; i++) l[127-8*i -: 8] = mem[i];
    return l;
  endfunction

  task automatic run_txn(input int id, input bit wr, input int pw, input bit bi,
                         input int wt, input int word);
    exp_t e;
    logic [127:0] pat;
    int n;
    for (int i = 0; i < 16; i++) pat[127-8*i -: 8] = 8'(id * 37 + i * 11 + 5);
    n = 4 << pw;
    sl_pw = pw; sl_bi = bi; sl_wait = wt;
    for (int i = 0; i < 16; i++) mem[i] = wr ? 8'h00 : pat[127-8*i -: 8];
    e.wr = wr; e.line = pat; e.id = id;
    e.ts_n   = bi ? n : 1;
    e.lock_n = bi ? n * (wt + 2) : 1 + n * (wt + 1);
    e.addr0  = 32'h2000_0100 | 32'(word * 4);
    sb.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = e.addr0 | 32'(id % 4);
    req_wdata = wr ? pat : ~pat;
    @(negedge clk);
    req_valid = 0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor
  int ts_cnt = 0, lock_cnt = 0, cyc = 0;
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(0, "watchdog", 128'(cyc), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
      if (rst_n && bus_ts && ts_cnt == 0 && sb.size() != 0) begin
        e = sb[0];
        // R2 first start is a burst at the word-aligned request address
        check(bus_burst && bus_addr == e.addr0 && bus_write == e.wr, "R2 start",
              128'(bus_addr), 128'(e.addr0));
      end
      if (rst_n) begin
        ts_cnt += int'(bus_ts);
        lock_cnt += int'(bus_lock);
      end
      if (rst_n && done && sb.size() != 0) begin
        e = sb.pop_front();
        // R9 R11 line content, R6 R7 R8 order and lanes
        check((e.wr ? mem_line() : rd_line) == e.line, "R9 R11 line data",
              e.wr ? mem_line() : rd_line, e.line);
        // R5 R6 R7 transfer starts
        check(ts_cnt == e.ts_n, "R5 R6 R7 ts count", 128'(ts_cnt), 128'(e.ts_n));
        // R10 R4 busy cycles
        check(lock_cnt == e.lock_n, "R10 lock cycles", 128'(lock_cnt), 128'(e.lock_n));
        ts_cnt = 0; lock_cnt = 0;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !bus_ts && !bus_lock && !bus_bdip, "R1 idle after reset",
          {bus_bdip, bus_lock, bus_ts, req_ready}, 128'h1);
    check(!done, "R11 no done after reset", 128'(done), 0);
    // id, wr, port, inhibit, wait, start word
    run_txn(1, 0, 0, 0, 0, 0);   // R5
    run_txn(2, 1, 0, 0, 1, 2);   // R5 R3
    run_txn(3, 0, 1, 0, 0, 1);   // R6
    run_txn(4, 1, 1, 0, 1, 3);   // R6
    run_txn(5, 0, 2, 0, 0, 2);   // R6 R10
    run_txn(6, 1, 2, 0, 0, 1);   // R6 R9
    run_txn(7, 0, 0, 1, 0, 3);   // R7 R8
    run_txn(8, 1, 0, 1, 1, 1);   // R7 R8
    run_txn(9, 0, 1, 1, 0, 2);   // R7 R8
    run_txn(10, 1, 2, 1, 0, 0);  // R7 R8
    run_txn(11, 0, 2, 1, 1, 3);  // R7 R8
    run_txn(12, 1, 1, 1, 0, 0);  // R7 R8
    @(negedge clk);
    check(req_ready && !bus_lock, "R10 released at end", 128'(bus_lock), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule